// File: doc/BRIEF.md
# Call/Return Context Stack with Trap Vectoring

This block keeps the saved execution context of a small controller core across subroutine calls, software traps and returns. Every entry holds a return address together with the global interrupt enable bit, the four ALU flags and the two register-bank select bits that were live when the entry was saved. Calls and traps share one bounded nesting depth of twelve levels by default.

A call saves the current context and sends the core to a supplied target address. A trap does the same, but it builds the target address from an internal interrupt base register and a 6-bit vector number. A trap can also clear the interrupt enable. A return pops the newest entry and always sends the core back to the saved address. Two options control what else comes back: a 2-bit field picks the interrupt-enable action, and a restore bit brings back the saved flags and bank selection. A return carries a condition input that the core has already evaluated. When that condition is false, the return does nothing.

Results come out one cycle after the request as a registered set: a load strobe, the new PC, and the new interrupt enable, flags and bank values that the core should take. Overflow and underflow pulses report requests that were refused.

Top module: `ctx_stack`

## Requirements
- R1: The stack accepts exactly DEPTH (12) nested saves, in any mix of calls and traps, before it counts as full.
- R2: An accepted call saves {next_pc, cur_gie, cur_flags, cur_bank}. One cycle later it drives pc_load_o=1, pc_new_o=call_target and gie_new_o=cur_gie. flags_new_o and bank_new_o equal the current values.
- R3: An accepted return drives pc_load_o=1 one cycle later, with pc_new_o equal to the address of the newest saved entry. That entry is then removed.
- R4: On a return, ret_gie_mode picks gie_new_o: 0 gives cur_gie, 1 gives the saved bit, 2 gives 1 and 3 gives 0.
- R5: On a return with ret_restore=1, flags_new_o and bank_new_o take the saved values. With ret_restore=0 they take cur_flags and cur_bank.
- R6: A trap sets pc_new_o to the interrupt base register in bits 15..8, zero in bits 7..6 and trap_vec in bits 5..0. ibr_we writes ibr_wdata into the base register.
- R7: A trap with trap_clr_gie=1 gives gie_new_o=0. With trap_clr_gie=0 it gives cur_gie. In both cases the saved GIE is the pre-trap value.
- R8: A return with ret_cond=0 has no effect: no load, no underflow, and the stack is unchanged.
- R9: A save request on a full stack drives ovf_o=1 for one cycle and pc_load_o=0, and leaves the stored entries unchanged.
- R10: A return with a true condition on an empty stack drives unf_o=1 for one cycle and pc_load_o=0.
- R11: When a save and a return are requested in the same cycle, the save is carried out and the return is ignored.
- R12: When call_req and trap_req are both asserted, the request acts as a trap.
- R13: After reset, pc_load_o, ovf_o and unf_o are 0 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Save context and jump to call_target |
| trap_req | input | 1 | Save context and jump to the vector address |
| ret_req | input | 1 | Return request |
| ret_cond | input | 1 | Return condition (1 = take the return) |
| ret_gie_mode | input | 2 | GIE action on return (0 keep, 1 saved, 2 set, 3 clear) |
| ret_restore | input | 1 | Restore the flags and bank selection on return |
| next_pc | input | 16 | Address to save as the return address |
| call_target | input | 16 | Call destination |
| trap_vec | input | 6 | Trap vector number |
| trap_clr_gie | input | 1 | Clear GIE when the trap is taken |
| cur_gie | input | 1 | Current interrupt enable |
| cur_flags | input | 4 | Current ALU flags {Z,C,N,V} |
| cur_bank | input | 2 | Current register-bank selects |
| ibr_we | input | 1 | Interrupt base register write enable |
| ibr_wdata | input | 8 | Interrupt base register write data |
| pc_load_o | output | 1 | New PC valid for this cycle |
| pc_new_o | output | 16 | New program counter |
| gie_new_o | output | 1 | New interrupt enable |
| flags_new_o | output | 4 | New ALU flags |
| bank_new_o | output | 2 | New bank selects |
| ovf_o | output | 1 | Save refused: stack full |
| unf_o | output | 1 | Return refused: stack empty |

## Verification
The stack is filled to the top with a mix of calls and traps whose addresses, flags, banks and GIE values differ at every level. It is then drained, and the drain walks through all four GIE modes and both restore settings. A wrong pop order, a swapped field or an option ignored therefore shows up as a mismatch. The current-context inputs during returns are the complements of the saved ones, so "unchanged" and "restored" cannot look the same. All 64 trap vectors are swept under three base-register values to expose a misplaced or unzeroed bit. Refused saves, empty returns, false conditions and simultaneous requests are each followed by pops that confirm the stored contents were not touched.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
   typedef enum logic [1:0] {
      GIE_KEEP  = 2'd0,
      GIE_SAVED = 2'd1,
      GIE_SET   = 2'd2,
      GIE_CLEAR = 2'd3
   } gie_mode_e;
endpackage

// File: rtl/ctx_lifo.sv
module ctx_lifo #(
   parameter int DEPTH = 12,
   parameter int W     = 23
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int PW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] cnt;
   logic [IW-1:0] wr_idx;
   logic [IW-1:0] top_idx;

   assign wr_idx  = cnt[IW-1:0];
   assign top_idx = IW'(cnt - PW'(1));
   assign full    = (cnt == PW'(DEPTH));
   assign empty   = (cnt == '0);
   assign rdata   = empty ? '0 : mem[top_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (push && !full) begin
         cnt <= cnt + PW'(1);
      end else if (pop && !empty) begin
         cnt <= cnt - PW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_idx] <= wdata;
   end

   // R1: occupancy never exceeds the configured depth
   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= PW'(DEPTH));

   // R1: occupancy moves by at most one level per cycle
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == $past(cnt)) || (cnt == $past(cnt) + PW'(1)) || (cnt == $past(cnt) - PW'(1)));

   // R11: the controller never asks for a save and a removal together
   p_no_dual_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));
endmodule

// File: rtl/ctx_vector.sv
module ctx_vector #(
   parameter int AW   = 16,
   parameter int IBRW = 8,
   parameter int VW   = 6
) (
   input  logic [IBRW-1:0] base,
   input  logic [VW-1:0]   vec,
   output logic [AW-1:0]   target
);
   localparam int PADW = AW - IBRW - VW;

   generate
      if (PADW < 0) begin : g_bad
         $error("ctx_vector: base and vector do not fit the address width");
      end else if (PADW == 0) begin : g_tight
         assign target = {base, vec};
      end else begin : g_pad
         assign target = {base, {PADW{1'b0}}, vec};
      end
   endgenerate
endmodule

// File: rtl/ctx_restore.sv
module ctx_restore
   import ctx_stack_pkg::*;
#(
   parameter int FW = 4,
   parameter int BW = 2
) (
   input  logic [1:0]    mode,
   input  logic          restore,
   input  logic          cur_gie,
   input  logic [FW-1:0] cur_flags,
   input  logic [BW-1:0] cur_bank,
   input  logic          saved_gie,
   input  logic [FW-1:0] saved_flags,
   input  logic [BW-1:0] saved_bank,
   output logic          gie,
   output logic [FW-1:0] flags,
   output logic [BW-1:0] bank
);
   always_comb begin
      unique case (gie_mode_e'(mode))
         GIE_KEEP:  gie = cur_gie;
         GIE_SAVED: gie = saved_gie;
         GIE_SET:   gie = 1'b1;
         GIE_CLEAR: gie = 1'b0;
         default:   gie = cur_gie;
      endcase
   end

   assign flags = restore ? saved_flags : cur_flags;
   assign bank  = restore ? saved_bank  : cur_bank;
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack #(
   parameter int DEPTH = 12,
   parameter int AW    = 16,
   parameter int IBRW  = 8,
   parameter int VW    = 6,
   parameter int FW    = 4,
   parameter int BW    = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            call_req,
   input  logic            trap_req,
   input  logic            ret_req,
   input  logic            ret_cond,
   input  logic [1:0]      ret_gie_mode,
   input  logic            ret_restore,
   input  logic [AW-1:0]   next_pc,
   input  logic [AW-1:0]   call_target,
   input  logic [VW-1:0]   trap_vec,
   input  logic            trap_clr_gie,
   input  logic            cur_gie,
   input  logic [FW-1:0]   cur_flags,
   input  logic [BW-1:0]   cur_bank,
   input  logic            ibr_we,
   input  logic [IBRW-1:0] ibr_wdata,
   output logic            pc_load_o,
   output logic [AW-1:0]   pc_new_o,
   output logic            gie_new_o,
   output logic [FW-1:0]   flags_new_o,
   output logic [BW-1:0]   bank_new_o,
   output logic            ovf_o,
   output logic            unf_o
);
   localparam int EW = AW + 1 + FW + BW;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("ctx_stack: DEPTH must be at least 1");
      end
      if (IBRW + VW > AW) begin : g_bad_vec
         $error("ctx_stack: vector fields exceed address width");
      end
   endgenerate

   logic [IBRW-1:0] ibr_q;
   logic            any_push, push_ok, ret_take, pop_ok, full, empty;
   logic [EW-1:0]   wdata, rdata;
   logic [AW-1:0]   pop_addr, vec_target;
   logic            pop_gie, rst_gie;
   logic [FW-1:0]   pop_flags, rst_flags;
   logic [BW-1:0]   pop_bank, rst_bank;

   assign any_push = call_req | trap_req;
   assign push_ok  = any_push & ~full;
   assign ret_take = ret_req & ret_cond & ~any_push;
   assign pop_ok   = ret_take & ~empty;
   assign wdata    = {next_pc, cur_gie, cur_flags, cur_bank};

   assign pop_addr  = rdata[EW-1 -: AW];
   assign pop_gie   = rdata[FW+BW];
   assign pop_flags = rdata[BW +: FW];
   assign pop_bank  = rdata[BW-1:0];

   ctx_lifo #(.DEPTH(DEPTH), .W(EW)) lifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_ok),
      .pop   (pop_ok),
      .wdata (wdata),
      .rdata (rdata),
      .full  (full),
      .empty (empty)
   );

   ctx_vector #(.AW(AW), .IBRW(IBRW), .VW(VW)) vector_i (
      .base   (ibr_q),
      .vec    (trap_vec),
      .target (vec_target)
   );

   ctx_restore #(.FW(FW), .BW(BW)) restore_i (
      .mode        (ret_gie_mode),
      .restore     (ret_restore),
      .cur_gie     (cur_gie),
      .cur_flags   (cur_flags),
      .cur_bank    (cur_bank),
      .saved_gie   (pop_gie),
      .saved_flags (pop_flags),
      .saved_bank  (pop_bank),
      .gie         (rst_gie),
      .flags       (rst_flags),
      .bank        (rst_bank)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ibr_q <= '0;
      else if (ibr_we) ibr_q <= ibr_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_load_o   <= 1'b0;
         pc_new_o    <= '0;
         gie_new_o   <= 1'b0;
         flags_new_o <= '0;
         bank_new_o  <= '0;
         ovf_o       <= 1'b0;
         unf_o       <= 1'b0;
      end else begin
         pc_load_o <= push_ok | pop_ok;
         ovf_o     <= any_push & full;
         unf_o     <= ret_take & empty;
         if (push_ok) begin
            pc_new_o    <= trap_req ? vec_target : call_target;
            gie_new_o   <= (trap_req && trap_clr_gie) ? 1'b0 : cur_gie;
            flags_new_o <= cur_flags;
            bank_new_o  <= cur_bank;
         end else if (pop_ok) begin
            pc_new_o    <= pop_addr;
            gie_new_o   <= rst_gie;
            flags_new_o <= rst_flags;
            bank_new_o  <= rst_bank;
         end
      end
   end

   // R9: overflow only follows a save request and never comes with a load
   p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> ($past(call_req || trap_req) && !pc_load_o));

   // R10: underflow only follows a taken return that lost no arbitration
   p_unf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |-> ($past(ret_req && ret_cond && !call_req && !trap_req) && !pc_load_o));

   // R8: a false condition produces neither load nor underflow
   p_cond_false_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !ret_cond && !call_req && !trap_req) |=> (!pc_load_o && !unf_o));

   // R6: the trap target carries the base register in its upper byte
   p_trap_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !full) |=> (pc_new_o[AW-1 -: IBRW] == $past(ibr_q)));

   // R4: set and clear modes force the interrupt enable
   p_gie_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && ret_gie_mode == 2'd2) |=> gie_new_o);
   p_gie_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && ret_gie_mode == 2'd3) |=> !gie_new_o);

   // R11: a save wins over a same-cycle return
   p_push_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && !trap_req && ret_req && !full) |=> (pc_load_o && pc_new_o == $past(call_target)));
endmodule

// File: tb/ctx_stack_tb_top.sv
module ctx_stack_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_req = 0, trap_req = 0, ret_req = 0, ret_cond = 0;
   logic [1:0]  ret_gie_mode = 0;
   logic        ret_restore = 0;
   logic [15:0] next_pc = 0, call_target = 0;
   logic [5:0]  trap_vec = 0;
   logic        trap_clr_gie = 0, cur_gie = 0;
   logic [3:0]  cur_flags = 0;
   logic [1:0]  cur_bank = 0;
   logic        ibr_we = 0;
   logic [7:0]  ibr_wdata = 0;
   logic        pc_load_o, gie_new_o, ovf_o, unf_o;
   logic [15:0] pc_new_o;
   logic [3:0]  flags_new_o;
   logic [1:0]  bank_new_o;

   int nchk = 0, nfail = 0;
   logic [15:0] s_addr [16];
   logic        s_gie  [16];
   logic [3:0]  s_fl   [16];
   logic [1:0]  s_bk   [16];
   int          sp = 0;
   logic [7:0]  ibr_m = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctx_stack dut_i (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      call_req = 0; trap_req = 0; ret_req = 0; ibr_we = 0;
   endtask

   task automatic set_ibr(logic [7:0] v);
      ibr_we = 1; ibr_wdata = v;
      cyc();
      ibr_m = v;
   endtask

   task automatic do_push(bit c, bit t, bit r, logic [15:0] npc, logic [15:0] tgt,
                          logic [5:0] v, bit clr, bit g, logic [3:0] fl, logic [1:0] bk);
      logic [15:0] epc;
      call_req = c; trap_req = t; ret_req = r; ret_cond = 1;
      next_pc = npc; call_target = tgt; trap_vec = v; trap_clr_gie = clr;
      cur_gie = g; cur_flags = fl; cur_bank = bk;
      cyc();
      if (sp == DEPTH) begin
         chk("R9 ovf", ovf_o, 1);
         chk("R9 no load", pc_load_o, 0);
      end else begin
         epc = t ? {ibr_m, 2'b00, v} : tgt;
         chk(t ? "R6/R12 trap pc" : "R2/R11 call pc", pc_new_o, epc);
         chk("R2 load", pc_load_o, 1);
         chk("R7 gie", gie_new_o, (t && clr) ? 1'b0 : g);
         chk("R2 flags", flags_new_o, fl);
         chk("R2 bank", bank_new_o, bk);
         chk("R1 no ovf", ovf_o, 0);
         s_addr[sp] = npc; s_gie[sp] = g; s_fl[sp] = fl; s_bk[sp] = bk;
         sp++;
      end
   endtask

   task automatic do_ret(bit cond, logic [1:0] mode, bit rf, bit g, logic [3:0] fl, logic [1:0] bk);
      logic eg;
      ret_req = 1; ret_cond = cond; ret_gie_mode = mode; ret_restore = rf;
      cur_gie = g; cur_flags = fl; cur_bank = bk;
      cyc();
      if (!cond) begin
         chk("R8 no load", pc_load_o, 0);
         chk("R8 no unf", unf_o, 0);
      end else if (sp == 0) begin
         chk("R10 unf", unf_o, 1);
         chk("R10 no load", pc_load_o, 0);
      end else begin
         sp--;
         case (mode)
            2'd0: eg = g;
            2'd1: eg = s_gie[sp];
            2'd2: eg = 1'b1;
            default: eg = 1'b0;
         endcase
         chk("R3 load", pc_load_o, 1);
         chk("R3 pc", pc_new_o, s_addr[sp]);
         chk("R4 gie", gie_new_o, eg);
         chk("R5 flags", flags_new_o, rf ? s_fl[sp] : fl);
         chk("R5 bank", bank_new_o, rf ? s_bk[sp] : bk);
         chk("R10 no unf", unf_o, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog R13 act=hung exp=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R13 load", pc_load_o, 0);
      chk("R13 ovf", ovf_o, 0);
      chk("R13 unf", unf_o, 0);
      rst_n = 1;
      do_ret(1, 0, 0, 0, 0, 0);             // R13 empty after reset, R10
      set_ibr(8'hA5);
      // R1 R2 R6 R7: fill with a mix of calls and traps
      for (int i = 0; i < DEPTH; i++) begin
         do_push(~i[0], i[0], 0, 16'h1000 + 16'(i) * 16'h0123, 16'h8000 + 16'(i),
                 6'(i * 5), (i % 3) == 1, i[1], 4'(i) ^ 4'h9, 2'(i));
      end
      do_push(1, 0, 0, 16'hDEAD, 16'h0001, 0, 0, 0, 0, 0);   // R1 R9
      do_push(0, 1, 0, 16'hBEEF, 16'h0002, 7, 1, 1, 4'hF, 3); // R9
      // R3 R4 R5: drain with all modes, current context complemented
      for (int i = 0; i < DEPTH; i++) begin
         do_ret(1, 2'(i), (i / 2) % 2 == 1, ~s_gie[sp-1], ~s_fl[sp-1], ~s_bk[sp-1]);
      end
      do_ret(1, 1, 1, 0, 0, 0);             // R10
      // R8
      do_push(1, 0, 0, 16'h4321, 16'h0400, 0, 0, 1, 4'h6, 2);
      do_ret(0, 1, 1, 0, 0, 0);
      do_ret(1, 1, 1, 0, 4'h9, 1);
      do_ret(0, 0, 0, 0, 0, 0);             // R8 on empty: no underflow
      // R11: same-cycle save and return, save wins
      do_push(1, 0, 0, 16'h2222, 16'h0500, 0, 0, 0, 4'h1, 1);
      do_push(1, 0, 1, 16'h3333, 16'h0600, 0, 0, 1, 4'h2, 2);
      do_ret(1, 1, 1, 0, 0, 0);
      do_ret(1, 1, 1, 0, 0, 0);
      // R12: call and trap together act as a trap
      do_push(1, 1, 0, 16'h5555, 16'h0700, 6'h2A, 0, 1, 4'h3, 3);
      do_ret(1, 0, 1, 1, 0, 0);
      // R6 R7: full vector sweep under several base values
      foreach (ibr_m[k]) begin end
      for (int b = 0; b < 3; b++) begin
         set_ibr(b == 0 ? 8'h00 : (b == 1 ? 8'hFF : 8'h3C));
         for (int v = 0; v < 64; v++) begin
            do_push(0, 1, 0, 16'(v * 257), 16'h0, 6'(v), v[0], 1, 4'(v), 2'(v));
            do_ret(1, 1, 1, 0, 0, 0);
         end
      end
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule